// File: doc/BRIEF.md
# Pin-to-Resource Input Router

The router ties eight multi-use input pins to four internal consumers: the gate/clock input of counter 0, the gate/clock input of counter 1, and the request lines of external interrupts 0 and 1. Each pin has its own 3-bit select field. The field either leaves the pin unconnected or names one consumer. For an interrupt target, the field also names the active polarity. Pins that pick the same consumer are merged by a logical OR. A pin that asks for falling/low activity is inverted before the merge, so every consumer receives one active-high combined signal.

The eight select fields live in four byte-wide control registers, with two fields in each. Software loads a register through a simple write strobe. For each interrupt, a mode bit sets how the request is formed. In level mode the request follows the combined signal. In edge mode a rising edge of the combined signal sets a pending flag, and an acknowledge input clears that flag. The counters and the interrupt controller sit outside this block.

Top module: `pin_resource_router`

## Requirements
- R1: While reset is low, and in the first cycle after it, every select field reads as code 0. `cnt_gate` and `irq_req` are both 0 in that cycle, whatever the pins do.
- R2: A write with `wr_en` high to register `wr_addr`=k loads `wr_data[2:0]` into the field of pin 2k and `wr_data[6:4]` into the field of pin 2k+1. Data bits 3 and 7 have no effect. The new fields act from the cycle after the write edge.
- R3: A pin whose code is 0 or 1 drives no resource.
- R4: Code 2 routes the pin to `cnt_gate[0]` and code 3 routes it to `cnt_gate[1]`. Both are combinational and active high.
- R5: Codes 4 and 5 feed the pin unchanged into the combined signal of interrupt 0 and interrupt 1, respectively. Codes 6 and 7 feed the inverted pin into interrupt 0 and interrupt 1, respectively.
- R6: When several pins select the same resource, that resource sees the OR of their contributions.
- R7: With `irq_mode[i]`=0 (level), `irq_req[i]` equals the combined signal of interrupt i in the same cycle.
- R8: With `irq_mode[i]`=1 (edge), a clock edge at which the combined signal is 1, after having been 0 at the previous edge, sets the pending flag. `irq_req[i]` shows the flag from the next cycle on.
- R9: In edge mode, `irq_ack[i]` high at a clock edge clears the pending flag, unless a new rising edge arrives at that same edge. In that case the flag is set.
- R10: In edge mode, a pending flag stays set until it is acknowledged, even after the combined signal falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | 2 | Index of the control register to write |
| wr_data | input | 8 | Write data: two select fields at [2:0] and [6:4] |
| pin_in | input | 8 | Multi-use pin levels, already synchronised |
| irq_mode | input | 2 | Per-interrupt detection mode, 1 = edge, 0 = level |
| irq_ack | input | 2 | Per-interrupt clear of the pending flag |
| cnt_gate | output | 2 | Combined gate/clock signals for counters 0 and 1 |
| irq_req | output | 2 | Interrupt requests 0 and 1 |

## Verification
The checker watches the timing rules of the interrupt path on every cycle: level mode follows the combined signal, a rising edge sets the flag one cycle later, an acknowledge clears it, and the flag holds while there is no acknowledge. It also checks that a counter gate is never active unless some field selects that counter, and that the first cycle after reset is quiet. Only the bench scenarios can show that each code reaches the right resource with the right polarity, that the two fields land on the right pins with bits 3 and 7 ignored, and that OR merging across arbitrary pin sets is correct. To show this, the bench sweeps every pin through every code and tries many random full configurations.

// File: rtl/router_pkg.sv
// Shared definitions for the pin-to-resource router.
// Assumes: select codes are fixed at 3 bits; resource order below is used
// as the index into per-pin contribution vectors.
package router_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_RES = 4;

    localparam int RES_CNT0 = 0;
    localparam int RES_CNT1 = 1;
    localparam int RES_IRQ0 = 2;
    localparam int RES_IRQ1 = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF_A   = 3'd0,
        SEL_OFF_B   = 3'd1,
        SEL_CNT0    = 3'd2,
        SEL_CNT1    = 3'd3,
        SEL_IRQ0_HI = 3'd4,
        SEL_IRQ1_HI = 3'd5,
        SEL_IRQ0_LO = 3'd6,
        SEL_IRQ1_LO = 3'd7
    } sel_code_e;
endpackage

// File: rtl/rsel_bank.sv
// Bank of control registers holding the per-pin select fields.
// Each register carries FIELDS_PER_REG fields spaced FIELD_STRIDE bits apart;
// the bits between fields are discarded. All fields reset to code 0.
// Assumes: NUM_PINS is a multiple of FIELDS_PER_REG.
module rsel_bank #(
    parameter int NUM_PINS       = 8,
    parameter int FIELDS_PER_REG = 2,
    parameter int REG_W          = 8,
    localparam int NUM_REGS      = NUM_PINS / FIELDS_PER_REG,
    localparam int ADDR_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int FIELD_STRIDE  = REG_W / FIELDS_PER_REG
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [REG_W-1:0]                      wr_data,
    output logic [NUM_PINS*router_pkg::SEL_W-1:0] sel_flat
);
    import router_pkg::*;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar f = 0; f < FIELDS_PER_REG; f++) begin : g_field
            localparam int PIN = r * FIELDS_PER_REG + f;
            logic [SEL_W-1:0] field_q;

            // Load this field when its register is addressed; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    field_q <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(r))) begin
                    field_q <= wr_data[f*FIELD_STRIDE +: SEL_W];
                end
            end

            assign sel_flat[PIN*SEL_W +: SEL_W] = field_q;
        end
    end
endmodule

// File: rtl/rsel_decode.sv
// Turns each pin and its select code into per-resource contributions,
// inverting falling/low selections, then ORs contributions per resource.
// Purely combinational. Assumes pin levels are already synchronous to clk.
module rsel_decode #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0]                   pin_in,
    input  logic [NUM_PINS*router_pkg::SEL_W-1:0] sel_flat,
    output logic [1:0]                            cnt_comb,
    output logic [1:0]                            irq_comb
);
    import router_pkg::*;

    logic [NUM_RES-1:0] contrib [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sel_code_e code;
        assign code = sel_code_e'(sel_flat[p*SEL_W +: SEL_W]);

        // Map one pin onto the resource its code names, with polarity.
        always_comb begin
            contrib[p] = '0;
            unique case (code)
                SEL_CNT0:    contrib[p][RES_CNT0] = pin_in[p];
                SEL_CNT1:    contrib[p][RES_CNT1] = pin_in[p];
                SEL_IRQ0_HI: contrib[p][RES_IRQ0] = pin_in[p];
                SEL_IRQ1_HI: contrib[p][RES_IRQ1] = pin_in[p];
                SEL_IRQ0_LO: contrib[p][RES_IRQ0] = ~pin_in[p];
                SEL_IRQ1_LO: contrib[p][RES_IRQ1] = ~pin_in[p];
                default:     contrib[p] = '0;
            endcase
        end
    end

    logic [NUM_RES-1:0] merged;

    // OR all pin contributions together per resource.
    always_comb begin
        merged = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            merged = merged | contrib[p];
        end
    end

    assign cnt_comb = {merged[RES_CNT1], merged[RES_CNT0]};
    assign irq_comb = {merged[RES_IRQ1], merged[RES_IRQ0]};
endmodule

// File: rtl/irq_detect.sv
// Edge or level request former for one interrupt.
// Level mode: request mirrors the combined signal. Edge mode: a 0->1 change
// between consecutive clock edges sets a pending flag; ack clears it, with a
// same-cycle edge taking priority. Pending is held clear in level mode.
module irq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic comb,
    input  logic edge_mode,
    input  logic ack,
    output logic req
);
    logic comb_q;
    logic pending;
    logic rise;

    assign rise = comb && !comb_q;

    // Track the previous combined level and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            comb_q <= comb;
            if (!edge_mode) begin
                pending <= 1'b0;
            end else if (rise) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
        end
    end

    assign req = edge_mode ? pending : comb;
endmodule

// File: rtl/pin_resource_router.sv
// Top of the pin-to-resource router: select register bank, pin decoder and
// one request former per interrupt.
// Assumes pin_in is synchronous to clk; outputs feed counters and the
// interrupt controller, which live elsewhere.
module pin_resource_router #(
    parameter int NUM_PINS       = 8,
    parameter int FIELDS_PER_REG = 2,
    parameter int REG_W          = 8,
    localparam int NUM_REGS      = NUM_PINS / FIELDS_PER_REG,
    localparam int ADDR_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int NUM_IRQ       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_IRQ-1:0]  irq_mode,
    input  logic [NUM_IRQ-1:0]  irq_ack,
    output logic [1:0]          cnt_gate,
    output logic [NUM_IRQ-1:0]  irq_req
);
    import router_pkg::*;

    logic [NUM_PINS*SEL_W-1:0] sel_flat;
    logic [NUM_IRQ-1:0]        irq_comb;

    rsel_bank #(
        .NUM_PINS      (NUM_PINS),
        .FIELDS_PER_REG(FIELDS_PER_REG),
        .REG_W         (REG_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_flat(sel_flat)
    );

    rsel_decode #(
        .NUM_PINS(NUM_PINS)
    ) u_decode (
        .pin_in  (pin_in),
        .sel_flat(sel_flat),
        .cnt_comb(cnt_gate),
        .irq_comb(irq_comb)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        irq_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .comb     (irq_comb[i]),
            .edge_mode(irq_mode[i]),
            .ack      (irq_ack[i]),
            .req      (irq_req[i])
        );
    end
endmodule

// File: rtl/router_chk.sv
// Checker for pin_resource_router, attached by bind. Observes the select
// fields, the combined interrupt signals and the ports.
module router_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [NUM_PINS*router_pkg::SEL_W-1:0] sel_flat,
    input logic [1:0]                            irq_comb,
    input logic [1:0]                            cnt_gate,
    input logic [1:0]                            irq_req,
    input logic [1:0]                            irq_mode,
    input logic [1:0]                            irq_ack
);
    import router_pkg::*;

    logic [1:0] has_cnt_sel;

    // Note which counters are named by at least one field.
    always_comb begin
        has_cnt_sel = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_flat[p*SEL_W +: SEL_W] == SEL_W'(2)) has_cnt_sel[0] = 1'b1;
            if (sel_flat[p*SEL_W +: SEL_W] == SEL_W'(3)) has_cnt_sel[1] = 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (cnt_gate == 2'b00 && irq_req == 2'b00));

    for (genvar k = 0; k < 2; k++) begin : g_k
        a_r4_gate_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_gate[k] |-> has_cnt_sel[k]);

        a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_mode[k] |-> (irq_req[k] == irq_comb[k]));

        a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[k] && irq_comb[k] && !$past(irq_comb[k]))
            |=> (irq_req[k] || !irq_mode[k]));

        a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[k] && irq_ack[k] && !(irq_comb[k] && !$past(irq_comb[k])))
            |=> (!irq_req[k] || !irq_mode[k]));

        a_r10_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[k] && irq_req[k] && !irq_ack[k])
            |=> (irq_req[k] || !irq_mode[k]));
    end
endmodule

bind pin_resource_router router_chk #(
    .NUM_PINS(NUM_PINS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_flat(sel_flat),
    .irq_comb(irq_comb),
    .cnt_gate(cnt_gate),
    .irq_req (irq_req),
    .irq_mode(irq_mode),
    .irq_ack (irq_ack)
);

// File: tb/pin_resource_router_test.sv
module pin_resource_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pin_in = '0;
    logic [1:0] irq_mode = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] cnt_gate;
    logic [1:0] irq_req;

    int checks = 0;
    int fails  = 0;
    logic [2:0] cfg [8];

    always #2 clk = ~clk;

    pin_resource_router uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_in(pin_in), .irq_mode(irq_mode),
        .irq_ack(irq_ack), .cnt_gate(cnt_gate), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load all registers from cfg; bits 3 and 7 carry junk (R2 says ignored).
    task automatic load_cfg();
        for (int r = 0; r < 4; r++) begin
            wr(2'(r), {1'b1, cfg[2*r+1], 1'b1, cfg[2*r]});
        end
    endtask

    // Expected {irq1, irq0, cnt1, cnt0} in level mode, from the code table.
    function automatic logic [3:0] model(input logic [7:0] pins);
        logic [3:0] e = '0;
        for (int p = 0; p < 8; p++) begin
            case (cfg[p])
                3'd2: e[0] |= pins[p];
                3'd3: e[1] |= pins[p];
                3'd4: e[2] |= pins[p];
                3'd5: e[3] |= pins[p];
                3'd6: e[2] |= ~pins[p];
                3'd7: e[3] |= ~pins[p];
                default: ;
            endcase
        end
        return e;
    endfunction

    task automatic step_chk(input string tag, input logic [7:0] pins,
                            input logic [1:0] ack, input logic exp_req0);
        @(negedge clk);
        pin_in = pins; irq_ack = ack;
        #1;
        chk(tag, {3'b000, irq_req[0]}, {3'b000, exp_req0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with pins active and edge mode requested
        pin_in = 8'hFF; irq_mode = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset outputs", {irq_req, cnt_gate}, 4'b0000);
        @(negedge clk);
        irq_mode = 2'b00;

        // R2: field placement, bits 3 and 7 ignored
        for (int p = 0; p < 8; p++) cfg[p] = 3'd0;
        cfg[2] = 3'd2; cfg[3] = 3'd7;
        wr(2'd1, 8'hFA);
        pin_in = 8'h04; #1;
        chk("R2 field placement", {irq_req, cnt_gate}, 4'b1001);
        pin_in = 8'h08; #1;
        chk("R2 field placement", {irq_req, cnt_gate}, 4'b0000);

        // R3 R4 R5 R7: every pin through every code, level mode
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                string tag;
                logic [7:0] pats [4];
                for (int q = 0; q < 8; q++) cfg[q] = 3'd0;
                cfg[p] = 3'(c);
                load_cfg();
                tag = (c < 2) ? "R3 no route" : (c < 4) ? "R4 counter route" : "R5 R7 irq route";
                pats[0] = 8'h00; pats[1] = 8'hFF;
                pats[2] = 8'(1 << p); pats[3] = ~8'(1 << p);
                for (int k = 0; k < 4; k++) begin
                    pin_in = pats[k]; #1;
                    chk(tag, {irq_req, cnt_gate}, model(pats[k]));
                end
            end
        end

        // R6: random full configurations, OR merging
        for (int n = 0; n < 80; n++) begin
            for (int q = 0; q < 8; q++) cfg[q] = 3'($urandom_range(0, 7));
            load_cfg();
            for (int k = 0; k < 4; k++) begin
                logic [7:0] pv = 8'($urandom);
                pin_in = pv; #1;
                chk("R6 or merge", {irq_req, cnt_gate}, model(pv));
            end
        end

        // R8 R9 R10: edge mode on irq0; pin0 code 4, pin1 code 6
        for (int q = 0; q < 8; q++) cfg[q] = 3'd0;
        cfg[0] = 3'd4; cfg[1] = 3'd6;
        load_cfg();
        @(negedge clk);
        irq_mode = 2'b01; pin_in = 8'h02;
        @(negedge clk);
        step_chk("R8 idle",            8'h02, 2'b00, 1'b0);
        step_chk("R8 not before edge", 8'h03, 2'b00, 1'b0);
        step_chk("R8 set on rise",     8'h03, 2'b00, 1'b1);
        step_chk("R10 held after fall", 8'h02, 2'b00, 1'b1);
        step_chk("R10 held",           8'h02, 2'b01, 1'b1);
        step_chk("R9 ack clears",      8'h02, 2'b00, 1'b0);
        step_chk("R5 R8 inverted edge", 8'h00, 2'b00, 1'b0);
        step_chk("R5 R8 inverted set", 8'h00, 2'b00, 1'b1);
        step_chk("R9 ack pending",     8'h02, 2'b01, 1'b1);
        step_chk("R9 cleared",         8'h02, 2'b00, 1'b0);
        step_chk("R9 edge with ack",   8'h03, 2'b01, 1'b0);
        step_chk("R9 edge beats ack",  8'h03, 2'b00, 1'b1);
        @(negedge clk);
        irq_mode = 2'b00; #1;
        chk("R7 back to level", {3'b000, irq_req[0]}, 4'b0001);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule